// File: doc/BRIEF.md
# Rotating Register Window Controller

This block maintains a rotating sixteen-register view onto a larger physical register file of `NAREG` words. The view starts at physical register `base*4` and wraps around the end of the array. Alongside the base pointer it holds a one-bit-per-window occupancy vector, the window start vector. It also holds the status fields that window handling needs: overflow-enable, exception-mode, call increment and saved base.

A decoder issues one operation per cycle on `op_i`. The operations are the call-entry frame allocation, the windowed return, the signed rotate, restoring the saved base, the stack-move occupancy check and a status load. The block works out every legality rule and writes the new stack pointer. It also computes the return address. When a frame must be spilled or filled, it classifies the event as an overflow or underflow of 4, 8 or 12 registers, so that a handler elsewhere can take over. Results and exception codes are registered and appear one cycle after the operation.

A separate read port and write port give access to the sixteen logical registers at the current base.

Top module: `win_reg_ctrl`

## Requirements
- R1: After reset the base is 0, the window start vector is 1 (only bit 0 set), overflow-enable, exception-mode, call increment and saved base are 0, and no exception or return is reported.
- R2: Logical register r (0..15) reads and writes physical register (base*4 + r) mod NAREG, so data written at one base is seen at r-4k after the base advances by k, including across the wrap.
- R3: A call-entry with source index above 3, with overflow-enable 0, or with exception-mode 1 reports illegal (code 1), sets exception-mode and leaves base, window start vector and registers unchanged.
- R4: A legal call-entry with no overflow writes logical register (callinc*4 + s) with register s minus imm*8, advances the base by callinc and sets the window start bit of the new base.
- R5: A call-entry overflows when any of the callinc window start bits just above the base (base+1 upward, wrapping) is set. The base then advances by n, the distance to the first set bit above the base. The old base goes to the saved-base field and exception-mode is set.
- R6: The overflow code depends on the count of clear bits just above that first set bit: 0 gives overflow-4 (code 3), 1 gives overflow-8 (code 4), 2 gives overflow-12 (code 5).
- R7: A windowed return takes n from bits 31:30 of logical register 0. It takes m as 1, 2 or 3 for the nearest set start bit at base-1, base-2 or base-3, and 0 if none is set. It is illegal (code 1, exception-mode set, base unchanged) when n is 0, when m is nonzero and differs from n, or when overflow-enable is 0 or exception-mode is 1.
- R8: A legal return whose new base (base-n) has its start bit set clears the old base's start bit. It reports ret_valid_o with ret_pc_o = {pc_hi_i, register0[29:0]}.
- R9: A legal return whose new base has a clear start bit still moves the base to base-n. It reports underflow-4/8/12 (codes 6/7/8) for n = 1/2/3, stores the old base in the saved-base field, sets exception-mode and does not assert ret_valid_o.
- R10: The stack-move check reports alloca (code 2) and sets exception-mode when none of the start bits at base-1, base-2, base-3 is set; otherwise it reports nothing. The base never changes.
- R11: A rotate adds the 4-bit two's complement rot_i to the base modulo NAREG/4.
- R12: A restore loads the base from the saved-base field. A status load sets callinc, overflow-enable and exception-mode from st_wdata_i bits [3:2], [1] and [0].
- R13: Every exception is reported for exactly one cycle, the cycle after the operation, with exception-mode high. Operation codes are entry 0, return 1, rotate 2, restore 3, stack-move 4, status load 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation code |
| src_idx_i | input | 4 | Call-entry source register index s |
| imm_i | input | 12 | Call-entry frame size in units of 8 |
| rot_i | input | 4 | Signed rotate amount |
| pc_hi_i | input | 2 | Upper two bits of the current PC |
| st_wdata_i | input | 4 | Status load value {callinc, woe, excm} |
| rd_idx_i | input | 4 | Logical read index |
| rd_data_o | output | 32 | Logical read data |
| wr_en_i | input | 1 | Logical write enable, ignored while op_valid_i is high |
| wr_idx_i | input | 4 | Logical write index |
| wr_data_i | input | 32 | Logical write data |
| base_o | output | log2(NAREG/4) | Window base |
| wstart_o | output | NAREG/4 | Window start vector |
| woe_o | output | 1 | Overflow-enable |
| excm_o | output | 1 | Exception-mode |
| callinc_o | output | 2 | Call increment |
| owb_o | output | log2(NAREG/4) | Saved base |
| exc_valid_o | output | 1 | Exception report strobe |
| exc_kind_o | output | 4 | Exception code |
| ret_valid_o | output | 1 | Completed return strobe |
| ret_pc_o | output | 32 | Return address |

## Verification
The hardest cases to reach are overflow-8 and overflow-12, since the window start vector cannot be written directly. They need a vector with a set bit one position above the base and a second set bit two or three positions higher. The bench builds such vectors by chaining call-entries with different call increments, rotating the base back, then issuing one more call-entry. Underflows come from rotating the base well away from every set bit before a return, so that m is 0 and the bit at the new base is clear.

// File: rtl/winreg_pkg.sv
package winreg_pkg;
  typedef enum logic [2:0] {
    OP_ENTRY   = 3'd0,
    OP_RETW    = 3'd1,
    OP_ROTW    = 3'd2,
    OP_RESTORE = 3'd3,
    OP_MOVSP   = 3'd4,
    OP_SETST   = 3'd5
  } win_op_e;

  typedef enum logic [3:0] {
    EXC_NONE    = 4'd0,
    EXC_ILLEGAL = 4'd1,
    EXC_ALLOCA  = 4'd2,
    EXC_OVF4    = 4'd3,
    EXC_OVF8    = 4'd4,
    EXC_OVF12   = 4'd5,
    EXC_UNF4    = 4'd6,
    EXC_UNF8    = 4'd7,
    EXC_UNF12   = 4'd8
  } win_exc_e;
endpackage

// File: rtl/win_map.sv
module win_map #(
  parameter int NAREG = 64,
  localparam int PW = $clog2(NAREG),
  localparam int BW = PW - 2
) (
  input  logic [BW-1:0] base_i,
  input  logic [3:0]    lidx_i,
  output logic [PW-1:0] pidx_i
);
  logic [PW:0] sum;
  assign sum    = {1'b0, base_i, 2'b00} + (PW+1)'(lidx_i);
  assign pidx_i = sum[PW-1:0];
endmodule

// File: rtl/win_scan.sv
module win_scan #(
  parameter int NW = 16,
  localparam int BW = $clog2(NW)
) (
  input  logic [NW-1:0] ws_i,
  input  logic [BW-1:0] base_i,
  input  logic [1:0]    callinc_i,
  output logic          ovf_o,
  output logic [BW-1:0] ovf_n_o,
  output logic [1:0]    tail_o,
  output logic [1:0]    near_o
);
  logic [NW-1:0] rot;
  logic [2:0]    cmask;
  int            first;

  // rot[i] is the start bit i+1 windows above the base
  always_comb begin
    for (int i = 0; i < NW; i++) rot[i] = ws_i[base_i + BW'(i + 1)];
    first = NW;
    for (int i = NW - 1; i >= 0; i--) if (rot[i]) first = i;
    tail_o = 2'd3;
    for (int k = NW - 1; k >= 0; k--)
      if (rot[k] && k > first && k <= first + 3) tail_o = 2'(k - first - 1);
  end

  assign cmask   = 3'((4'd1 << callinc_i) - 4'd1);
  assign ovf_o   = |(rot[2:0] & cmask);
  assign ovf_n_o = BW'(first + 1);

  always_comb begin
    if (ws_i[base_i - BW'(1)])      near_o = 2'd1;
    else if (ws_i[base_i - BW'(2)]) near_o = 2'd2;
    else if (ws_i[base_i - BW'(3)]) near_o = 2'd3;
    else                            near_o = 2'd0;
  end
endmodule

// File: rtl/win_regfile.sv
module win_regfile #(
  parameter int NAREG = 64,
  parameter int XLEN  = 32,
  parameter int NRD   = 3,
  localparam int PW = $clog2(NAREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [PW-1:0]   waddr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [PW-1:0]   raddr_i [NRD],
  output logic [XLEN-1:0] rdata_o [NRD]
);
  logic [XLEN-1:0] mem_q [NAREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NAREG; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata_o[g] = mem_q[raddr_i[g]];
  end
endmodule

// File: rtl/win_reg_ctrl.sv
module win_reg_ctrl
  import winreg_pkg::*;
#(
  parameter int NAREG = 64,
  parameter int XLEN  = 32,
  parameter int IMM_W = 12,
  localparam int NW = NAREG / 4,
  localparam int BW = $clog2(NW),
  localparam int PW = $clog2(NAREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_valid_i,
  input  logic [2:0]       op_i,
  input  logic [3:0]       src_idx_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [3:0]       rot_i,
  input  logic [1:0]       pc_hi_i,
  input  logic [3:0]       st_wdata_i,
  input  logic [3:0]       rd_idx_i,
  output logic [XLEN-1:0]  rd_data_o,
  input  logic             wr_en_i,
  input  logic [3:0]       wr_idx_i,
  input  logic [XLEN-1:0]  wr_data_i,
  output logic [BW-1:0]    base_o,
  output logic [NW-1:0]    wstart_o,
  output logic             woe_o,
  output logic             excm_o,
  output logic [1:0]       callinc_o,
  output logic [BW-1:0]    owb_o,
  output logic             exc_valid_o,
  output logic [3:0]       exc_kind_o,
  output logic             ret_valid_o,
  output logic [XLEN-1:0]  ret_pc_o
);
  localparam int NRD = 3; // 0: user read, 1: entry source, 2: logical r0

  logic [BW-1:0]   base_q, base_d, owb_q, owb_d;
  logic [NW-1:0]   ws_q, ws_d;
  logic            woe_q, woe_d, excm_q, excm_d;
  logic [1:0]      callinc_q, callinc_d;
  logic            exc_valid_q, exc_valid_d, ret_valid_q, ret_valid_d;
  win_exc_e        exc_kind_q, exc_kind_d;
  logic [XLEN-1:0] ret_pc_q, ret_pc_d;

  logic [3:0]      rd_lidx [NRD];
  logic [PW-1:0]   rf_raddr [NRD];
  logic [XLEN-1:0] rf_rdata [NRD];
  logic            rf_we;
  logic [3:0]      rf_wlidx;
  logic [PW-1:0]   rf_waddr;
  logic [XLEN-1:0] rf_wdata;

  logic            ovf;
  logic [BW-1:0]   ovf_n;
  logic [1:0]      ovf_tail, near_m;
  logic [1:0]      ret_n;
  logic [BW-1:0]   ret_base, entry_base, rot_base;
  logic            entry_bad, retw_bad;
  win_op_e         op;

  assign op = win_op_e'(op_i);

  assign rd_lidx[0] = rd_idx_i;
  assign rd_lidx[1] = src_idx_i;
  assign rd_lidx[2] = 4'd0;

  for (genvar g = 0; g < NRD; g++) begin : g_map
    win_map #(.NAREG(NAREG)) u_map (
      .base_i(base_q), .lidx_i(rd_lidx[g]), .pidx_i(rf_raddr[g])
    );
  end

  win_map #(.NAREG(NAREG)) u_wmap (
    .base_i(base_q), .lidx_i(rf_wlidx), .pidx_i(rf_waddr)
  );

  win_regfile #(.NAREG(NAREG), .XLEN(XLEN), .NRD(NRD)) u_rf (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(rf_we), .waddr_i(rf_waddr),
    .wdata_i(rf_wdata), .raddr_i(rf_raddr), .rdata_o(rf_rdata)
  );

  win_scan #(.NW(NW)) u_scan (
    .ws_i(ws_q), .base_i(base_q), .callinc_i(callinc_q),
    .ovf_o(ovf), .ovf_n_o(ovf_n), .tail_o(ovf_tail), .near_o(near_m)
  );

  assign ret_n      = rf_rdata[2][XLEN-1:XLEN-2];
  assign ret_base   = base_q - BW'(ret_n);
  assign entry_base = base_q + BW'(callinc_q);
  assign rot_base   = base_q + BW'($signed(rot_i));
  assign entry_bad  = (src_idx_i > 4'd3) || !woe_q || excm_q;
  assign retw_bad   = (ret_n == 2'd0) || (near_m != 2'd0 && near_m != ret_n) ||
                      !woe_q || excm_q;

  always_comb begin
    base_d      = base_q;
    ws_d        = ws_q;
    owb_d       = owb_q;
    woe_d       = woe_q;
    excm_d      = excm_q;
    callinc_d   = callinc_q;
    exc_valid_d = 1'b0;
    exc_kind_d  = EXC_NONE;
    ret_valid_d = 1'b0;
    ret_pc_d    = ret_pc_q;
    rf_we       = wr_en_i && !op_valid_i;
    rf_wlidx    = wr_idx_i;
    rf_wdata    = wr_data_i;
    if (op_valid_i) begin
      unique case (op)
        OP_ENTRY: begin
          if (entry_bad) begin
            exc_valid_d = 1'b1;
            exc_kind_d  = EXC_ILLEGAL;
            excm_d      = 1'b1;
          end else if (ovf) begin
            base_d = base_q + ovf_n;
            owb_d  = base_q;
            excm_d = 1'b1;
            exc_valid_d = (ovf_tail != 2'd3);
            case (ovf_tail)
              2'd0:    exc_kind_d = EXC_OVF4;
              2'd1:    exc_kind_d = EXC_OVF8;
              2'd2:    exc_kind_d = EXC_OVF12;
              default: exc_kind_d = EXC_NONE;
            endcase
          end else begin
            rf_we    = 1'b1;
            rf_wlidx = {callinc_q, src_idx_i[1:0]};
            rf_wdata = rf_rdata[1] - (XLEN'(imm_i) << 3);
            base_d   = entry_base;
            ws_d     = ws_q | (NW'(1) << entry_base);
          end
        end
        OP_RETW: begin
          if (retw_bad) begin
            exc_valid_d = 1'b1;
            exc_kind_d  = EXC_ILLEGAL;
            excm_d      = 1'b1;
          end else begin
            base_d = ret_base;
            if (ws_q[ret_base]) begin
              ws_d        = ws_q & ~(NW'(1) << base_q);
              ret_valid_d = 1'b1;
              ret_pc_d    = {pc_hi_i, rf_rdata[2][XLEN-3:0]};
            end else begin
              owb_d       = base_q;
              excm_d      = 1'b1;
              exc_valid_d = 1'b1;
              case (ret_n)
                2'd1:    exc_kind_d = EXC_UNF4;
                2'd2:    exc_kind_d = EXC_UNF8;
                default: exc_kind_d = EXC_UNF12;
              endcase
            end
          end
        end
        OP_ROTW:    base_d = rot_base;
        OP_RESTORE: base_d = owb_q;
        OP_MOVSP: begin
          if (near_m == 2'd0) begin
            exc_valid_d = 1'b1;
            exc_kind_d  = EXC_ALLOCA;
            excm_d      = 1'b1;
          end
        end
        OP_SETST: begin
          callinc_d = st_wdata_i[3:2];
          woe_d     = st_wdata_i[1];
          excm_d    = st_wdata_i[0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q      <= '0;
      ws_q        <= NW'(1);
      owb_q       <= '0;
      woe_q       <= 1'b0;
      excm_q      <= 1'b0;
      callinc_q   <= '0;
      exc_valid_q <= 1'b0;
      exc_kind_q  <= EXC_NONE;
      ret_valid_q <= 1'b0;
      ret_pc_q    <= '0;
    end else begin
      base_q      <= base_d;
      ws_q        <= ws_d;
      owb_q       <= owb_d;
      woe_q       <= woe_d;
      excm_q      <= excm_d;
      callinc_q   <= callinc_d;
      exc_valid_q <= exc_valid_d;
      exc_kind_q  <= exc_kind_d;
      ret_valid_q <= ret_valid_d;
      ret_pc_q    <= ret_pc_d;
    end
  end

  assign rd_data_o   = rf_rdata[0];
  assign base_o      = base_q;
  assign wstart_o    = ws_q;
  assign woe_o       = woe_q;
  assign excm_o      = excm_q;
  assign callinc_o   = callinc_q;
  assign owb_o       = owb_q;
  assign exc_valid_o = exc_valid_q;
  assign exc_kind_o  = exc_kind_q;
  assign ret_valid_o = ret_valid_q;
  assign ret_pc_o    = ret_pc_q;
endmodule

// File: rtl/win_reg_ctrl_chk.sv
module win_reg_ctrl_chk #(
  parameter int NAREG = 64,
  localparam int NW = NAREG / 4,
  localparam int BW = $clog2(NW)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          op_valid_i,
  input logic [2:0]    op_i,
  input logic [3:0]    src_idx_i,
  input logic [3:0]    rot_i,
  input logic [BW-1:0] base_o,
  input logic [NW-1:0] wstart_o,
  input logic          woe_o,
  input logic          excm_o,
  input logic [BW-1:0] owb_o,
  input logic          exc_valid_o,
  input logic [3:0]    exc_kind_o,
  input logic          ret_valid_o
);
  logic [BW-1:0] rot_b;
  assign rot_b = BW'($signed(rot_i));

  a_r13_exc_sets_excm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_o |-> excm_o);

  a_r13_exc_after_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_o |-> $past(op_valid_i));

  a_r4_entry_sets_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 3'd0 && woe_o && !excm_o && src_idx_i < 4'd4)
    |=> (excm_o || wstart_o[base_o]));

  a_r5_ovf_saves_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_valid_o && exc_kind_o >= 4'd3 && exc_kind_o <= 4'd5) |-> owb_o == $past(base_o));

  a_r3_illegal_keeps_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_valid_o && exc_kind_o == 4'd1) |-> (base_o == $past(base_o) && wstart_o == $past(wstart_o)));

  a_r8_ret_clears_old: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_o |-> !wstart_o[$past(base_o)]);

  a_r11_rotate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 3'd2) |=> base_o == $past(base_o + rot_b));

  a_r12_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 3'd3) |=> base_o == $past(owb_o));

  a_r10_movsp_keeps_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 3'd4) |=> base_o == $past(base_o));
endmodule

bind win_reg_ctrl win_reg_ctrl_chk #(.NAREG(NAREG)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_valid_i(op_valid_i), .op_i(op_i),
  .src_idx_i(src_idx_i), .rot_i(rot_i), .base_o(base_o), .wstart_o(wstart_o),
  .woe_o(woe_o), .excm_o(excm_o), .owb_o(owb_o), .exc_valid_o(exc_valid_o),
  .exc_kind_o(exc_kind_o), .ret_valid_o(ret_valid_o)
);

// File: tb/win_reg_ctrl_tb_top.sv
`timescale 1ns/1ps
module win_reg_ctrl_tb_top;
  localparam int NAREG = 64;
  localparam int NW = NAREG / 4;
  localparam int BW = $clog2(NW);
  localparam logic [2:0] ENTRY = 3'd0, RETW = 3'd1, ROTW = 3'd2, RESTORE = 3'd3,
                         MOVSP = 3'd4, SETST = 3'd5;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic op_valid_i = 1'b0;
  logic [2:0] op_i = '0;
  logic [3:0] src_idx_i = '0, rot_i = '0, st_wdata_i = '0, rd_idx_i = '0, wr_idx_i = '0;
  logic [11:0] imm_i = '0;
  logic [1:0] pc_hi_i = '0;
  logic wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0, rd_data_o, ret_pc_o;
  logic [BW-1:0] base_o, owb_o;
  logic [NW-1:0] wstart_o;
  logic woe_o, excm_o, exc_valid_o, ret_valid_o;
  logic [1:0] callinc_o;
  logic [3:0] exc_kind_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  win_reg_ctrl #(.NAREG(NAREG)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .op_valid_i(op_valid_i), .op_i(op_i),
    .src_idx_i(src_idx_i), .imm_i(imm_i), .rot_i(rot_i), .pc_hi_i(pc_hi_i),
    .st_wdata_i(st_wdata_i), .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o),
    .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
    .base_o(base_o), .wstart_o(wstart_o), .woe_o(woe_o), .excm_o(excm_o),
    .callinc_o(callinc_o), .owb_o(owb_o), .exc_valid_o(exc_valid_o),
    .exc_kind_o(exc_kind_o), .ret_valid_o(ret_valid_o), .ret_pc_o(ret_pc_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // drive at a falling edge, result registered at the rising edge, sample at the next falling edge
  task automatic do_op(input logic [2:0] op, input logic [3:0] s = 4'd0,
                       input logic [11:0] imm = 12'd0, input logic [3:0] rot = 4'd0,
                       input logic [1:0] pch = 2'd0, input logic [3:0] st = 4'd0);
    op_i = op; src_idx_i = s; imm_i = imm; rot_i = rot; pc_hi_i = pch; st_wdata_i = st;
    op_valid_i = 1'b1;
    @(negedge clk);
    op_valid_i = 1'b0;
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    wr_idx_i = idx; wr_data_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [31:0] d);
    rd_idx_i = idx;
    #0.5;
    d = rd_data_o;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 base", 32'(base_o), 0);
    chk("R1 wstart", 32'(wstart_o), 1);
    chk("R1 status", {28'd0, woe_o, excm_o, callinc_o}, 0);
    chk("R1 owb", 32'(owb_o), 0);
    chk("R1 strobes", {30'd0, exc_valid_o, ret_valid_o}, 0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    do_reset();
    wr(4'd5, 32'hA5);
    do_op(ROTW, .rot(4'd1));
    chk("R11 rot +1", 32'(base_o), 1);
    rd(4'd1, d); chk("R2 shifted view", d, 32'hA5);
    do_op(ROTW, .rot(4'hE));
    chk("R11 rot -2 wraps", 32'(base_o), 15);
    wr(4'd4, 32'h1234);
    do_op(ROTW, .rot(4'd1));
    rd(4'd0, d); chk("R2 wrap around array end", d, 32'h1234);
    do_op(ROTW, .rot(4'd7));
    chk("R11 rot +7", 32'(base_o), 7);
  endtask

  task automatic t_entry_illegal();
    do_reset();
    do_op(ENTRY);
    chk("R3 woe=0 illegal", {27'd0, exc_valid_o, exc_kind_o}, {27'd0, 1'b1, 4'd1});
    chk("R3 excm set", 32'(excm_o), 1);
    chk("R13 strobe one cycle", 32'(exc_valid_o), 1);
    @(negedge clk);
    chk("R13 strobe dropped", 32'(exc_valid_o), 0);
    do_op(SETST, .st(4'b0010));
    do_op(ENTRY, .s(4'd4));
    chk("R3 s>3 illegal", 32'(exc_kind_o), 1);
    chk("R3 base kept", 32'(base_o), 0);
    chk("R3 wstart kept", 32'(wstart_o), 1);
    do_op(SETST, .st(4'b0011));
    do_op(ENTRY);
    chk("R3 excm=1 illegal", {27'd0, exc_valid_o, exc_kind_o}, {27'd0, 1'b1, 4'd1});
  endtask

  task automatic t_entry_ok();
    logic [31:0] d;
    do_reset();
    do_op(SETST, .st(4'b0110));
    chk("R12 status load", {28'd0, callinc_o, woe_o, excm_o}, 32'b0110);
    wr(4'd1, 32'h1000);
    do_op(ENTRY, .s(4'd1), .imm(12'd2));
    chk("R4 no exc", 32'(exc_valid_o), 0);
    chk("R4 base", 32'(base_o), 1);
    chk("R4 wstart", 32'(wstart_o), 32'h3);
    rd(4'd1, d); chk("R4 new sp", d, 32'hFF0);
    do_op(SETST, .st(4'b1110));
    wr(4'd2, 32'h500);
    do_op(ENTRY, .s(4'd2), .imm(12'd1));
    chk("R4 callinc3 base", 32'(base_o), 4);
    chk("R4 callinc3 wstart", 32'(wstart_o), 32'h13);
    rd(4'd2, d); chk("R4 callinc3 sp", d, 32'h4F8);
  endtask

  task automatic t_overflow();
    // overflow-4
    do_reset();
    do_op(SETST, .st(4'b0110));
    do_op(ENTRY); do_op(ENTRY);
    do_op(ROTW, .rot(4'hE));
    do_op(ENTRY);
    chk("R6 ovf4 code", {27'd0, exc_valid_o, exc_kind_o}, {27'd0, 1'b1, 4'd3});
    chk("R5 ovf base", 32'(base_o), 1);
    chk("R5 ovf owb", 32'(owb_o), 0);
    chk("R5 ovf excm", 32'(excm_o), 1);
    chk("R5 ovf wstart kept", 32'(wstart_o), 32'h7);
    // overflow-8
    do_reset();
    do_op(SETST, .st(4'b0110)); do_op(ENTRY);
    do_op(SETST, .st(4'b1010)); do_op(ENTRY);
    do_op(ROTW, .rot(4'hD));
    do_op(SETST, .st(4'b0110)); do_op(ENTRY);
    chk("R6 ovf8 code", 32'(exc_kind_o), 4);
    chk("R5 ovf8 base", 32'(base_o), 1);
    // overflow-12
    do_reset();
    do_op(SETST, .st(4'b0110)); do_op(ENTRY);
    do_op(SETST, .st(4'b1110)); do_op(ENTRY);
    do_op(ROTW, .rot(4'hC));
    do_op(SETST, .st(4'b0110)); do_op(ENTRY);
    chk("R6 ovf12 code", 32'(exc_kind_o), 5);
    chk("R5 ovf12 owb", 32'(owb_o), 0);
    // n = 2
    do_reset();
    do_op(SETST, .st(4'b1010)); do_op(ENTRY);
    do_op(SETST, .st(4'b0110)); do_op(ENTRY);
    do_op(ROTW, .rot(4'hD));
    do_op(SETST, .st(4'b1010)); do_op(ENTRY);
    chk("R5 ovf n=2 base", 32'(base_o), 2);
    chk("R6 ovf n=2 code", 32'(exc_kind_o), 3);
  endtask

  task automatic t_retw_ok();
    do_reset();
    do_op(SETST, .st(4'b0110)); do_op(ENTRY);
    wr(4'd0, 32'h4000_0123);
    do_op(RETW, .pch(2'b11));
    chk("R8 ret valid", {30'd0, ret_valid_o, exc_valid_o}, 32'b10);
    chk("R8 ret pc", ret_pc_o, 32'hC000_0123);
    chk("R8 base", 32'(base_o), 0);
    chk("R8 old bit cleared", 32'(wstart_o), 1);
  endtask

  task automatic t_retw_illegal();
    do_reset();
    do_op(SETST, .st(4'b0110)); do_op(ENTRY);
    wr(4'd0, 32'h0);
    do_op(RETW);
    chk("R7 n=0 illegal", 32'(exc_kind_o), 1);
    chk("R7 base kept", 32'(base_o), 1);
    do_op(SETST, .st(4'b0110));
    wr(4'd0, 32'h8000_0000);
    do_op(RETW);
    chk("R7 n!=m illegal", {27'd0, exc_valid_o, exc_kind_o}, {27'd0, 1'b1, 4'd1});
    do_op(SETST, .st(4'b0111));
    wr(4'd0, 32'h4000_0000);
    do_op(RETW);
    chk("R7 excm illegal", 32'(exc_kind_o), 1);
    chk("R7 no return", 32'(ret_valid_o), 0);
  endtask

  task automatic t_underflow();
    do_reset();
    do_op(SETST, .st(4'b0010));
    do_op(ROTW, .rot(4'd5));
    wr(4'd0, 32'h4000_0000);
    do_op(RETW);
    chk("R9 unf4 code", {27'd0, exc_valid_o, exc_kind_o}, {27'd0, 1'b1, 4'd6});
    chk("R9 unf4 base", 32'(base_o), 4);
    chk("R9 unf4 owb", 32'(owb_o), 5);
    chk("R9 no return", 32'(ret_valid_o), 0);
    do_op(RESTORE);
    chk("R12 restore", 32'(base_o), 5);
    do_op(SETST, .st(4'b0010));
    wr(4'd0, 32'h8000_0000);
    do_op(RETW);
    chk("R9 unf8", {28'd0, exc_kind_o} | (32'(base_o) << 8), 32'h307);
    do_op(RESTORE);
    do_op(SETST, .st(4'b0010));
    wr(4'd0, 32'hC000_0000);
    do_op(RETW);
    chk("R9 unf12", {28'd0, exc_kind_o} | (32'(base_o) << 8), 32'h208);
  endtask

  task automatic t_movsp();
    do_reset();
    do_op(MOVSP);
    chk("R10 alloca", {27'd0, exc_valid_o, exc_kind_o}, {27'd0, 1'b1, 4'd2});
    chk("R10 alloca excm", 32'(excm_o), 1);
    do_reset();
    do_op(ROTW, .rot(4'd2));
    do_op(MOVSP);
    chk("R10 near bit, no exc", 32'(exc_valid_o), 0);
    do_op(ROTW, .rot(4'd1));
    do_op(MOVSP);
    chk("R10 base-3 bit, no exc", 32'(exc_valid_o), 0);
    do_op(ROTW, .rot(4'd1));
    do_op(MOVSP);
    chk("R10 far, alloca", 32'(exc_kind_o), 2);
    chk("R10 base kept", 32'(base_o), 4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_map();
    t_entry_illegal();
    t_entry_ok();
    t_overflow();
    t_retw_ok();
    t_retw_illegal();
    t_underflow();
    t_movsp();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule